// File: doc/BRIEF.md
# Multiplexed LED Column Shift Driver

This block feeds the column side of one half of a time-multiplexed LED matrix. The columns hang on a daisy chain of serial current-sink shift registers that is 192 bits long. The anodes are 16 power sources. An external board steps through those sources in a fixed order, about 125 µs per row slot. The block keeps no scan timer of its own. It follows the external row strobe. On each accepted strobe rising edge it advances its row index. It then shifts that row's 192 column bits, preceded by a configurable run of zero padding bits, out on a serial data and serial clock pair. Finally it raises its own latch output so the chain transfers the word to its outputs.

A sampled tap on one anode source marks the start of the row sequence. A tap edge pulls the row index back to zero. When the tap edge does not agree with the row counter, the block flags lost synchronisation and shifts all-zero words until the counter and the tap agree again. The frame is held in two banks of 16 rows. The host writes rows into the hidden bank and then requests a swap. The swap takes effect at the next accepted strobe, so a frame always changes as a whole at a row boundary.

Top module: `led_row_shifter`

## Requirements
- R1: While reset is asserted and right after it, `sck`, `sdo` and `latch_out` are 0 and `sync_lost` is 1.
- R2: A rising edge on `strb_in` while the block is idle starts a transfer of exactly PAD_BITS+CHAIN_BITS bits. `sck` is high and low for DIV_HALF clock cycles each. `sdo` changes only in the cycle `sck` falls and stays steady across every `sck` rising edge.
- R3: Each transfer sends PAD_BITS zero bits first, then row bit CHAIN_BITS-1 down to bit 0, one bit per `sck` rising edge.
- R4: In the cycle after the last `sck` falling edge, `latch_out` goes high. It stays high for exactly LATCH_LEN cycles, after which the block is idle.
- R5: Rising edges on `strb_in` that arrive while a transfer or latch pulse is in progress are ignored. They neither restart the transfer nor advance the row.
- R6: Each accepted strobe advances the row index by one, wrapping from 15 to 0. If a rising edge on `tap_in` has been seen since the previous accepted strobe, the row index becomes 0 instead.
- R7: A cycle is aligned when a tap edge is paired with a strobe that leaves row 15. A tap edge with any other row, or row 15 left without a tap edge, is a mismatch. A mismatch sets `sync_lost` and clears the alignment count. Two aligned cycles with no mismatch between them clear `sync_lost`. After reset the row index reads 15.
- R8: Every bit of a transfer that starts while `sync_lost` is set (including its update at that same strobe) is 0.
- R9: `wr_en` writes `wr_data` into row `wr_row` of the hidden bank, and a write there does not change what is shifted. A `wr_swap` pulse is held pending until the next accepted strobe. At that strobe the banks exchange roles, before the row is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_in | input | 1 | Row strobe from the scan board (synchronous) |
| tap_in | input | 1 | Sampled level of one anode power source |
| wr_en | input | 1 | Write strobe for the hidden frame bank |
| wr_row | input | 4 | Row written by `wr_en` |
| wr_data | input | 192 | Column bits for the written row |
| wr_swap | input | 1 | Request to exchange banks at the next row boundary |
| sdo | output | 1 | Serial data to the shift chain |
| sck | output | 1 | Serial clock to the shift chain |
| latch_out | output | 1 | Regenerated latch strobe to the shift chain |
| sync_lost | output | 1 | Row counter not yet aligned with the anode tap |

## Verification
Row advance and resynchronisation land on the same accepted strobe: a tap edge arriving one cycle before the strobe both forces the row to zero and updates the lock state. The bench provokes this at row 15, at row 4 and without any tap at row 15. Each case is judged by the shifted word that follows (zeros, or the row-zero pattern) and by `sync_lost`. A swap request pending at that same strobe is also checked, by seeing the new bank's row in that very transfer.

// File: rtl/led_row_shifter.sv
module led_row_shifter #(
  parameter int CHAIN_BITS = 192,
  parameter int ROWS       = 16,
  parameter int PAD_BITS   = 8,
  parameter int DIV_HALF   = 64,
  parameter int LATCH_LEN  = 800
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          strb_in,
  input  logic                          tap_in,
  input  logic                          wr_en,
  input  logic [$clog2(ROWS)-1:0]       wr_row,
  input  logic [CHAIN_BITS-1:0]         wr_data,
  input  logic                          wr_swap,
  output logic                          sdo,
  output logic                          sck,
  output logic                          latch_out,
  output logic                          sync_lost
);
  localparam int TOT = PAD_BITS + CHAIN_BITS;
  localparam int RW  = $clog2(ROWS);
  localparam int CW  = $clog2(TOT + 1);
  localparam int PW  = $clog2(DIV_HALF + 1);
  localparam int LW  = $clog2(LATCH_LEN + 1);

  typedef enum logic [1:0] {IDLE, SHIFT, LATCH} st_t;

  st_t                  st;
  logic [TOT-1:0]       sh;
  logic [CW-1:0]        cnt;
  logic [PW-1:0]        ph;
  logic [LW-1:0]        lcnt;
  logic [RW-1:0]        row;
  logic [1:0]           good;
  logic                 front, swap_pend, tap_seen, tap_q, strb_q;
  logic [CHAIN_BITS-1:0] mem [2][ROWS];

  logic                 acc, tap_hit, at_last, aligned, mism, lost_nx, front_nx;
  logic [1:0]           good_nx;
  logic [RW-1:0]        row_nx;
  logic [CHAIN_BITS-1:0] rd;

  assign acc      = (st == IDLE) && strb_in && !strb_q;
  assign tap_hit  = tap_seen || (tap_in && !tap_q);
  assign at_last  = (row == RW'(ROWS - 1));
  assign aligned  = tap_hit && at_last;
  assign mism     = tap_hit != at_last;
  assign row_nx   = tap_hit ? '0 : (at_last ? '0 : row + 1'b1);
  assign front_nx = front ^ (swap_pend || wr_swap);
  assign rd       = mem[front_nx][row_nx];

  always_comb begin
    good_nx = good;
    lost_nx = sync_lost;
    if (mism) begin
      good_nx = 2'd0;
      lost_nx = 1'b1;
    end else if (aligned) begin
      good_nx = (good == 2'd2) ? 2'd2 : good + 2'd1;
      if (good_nx == 2'd2) lost_nx = 1'b0;
    end
  end

  assign sdo       = sh[TOT-1];
  assign latch_out = (st == LATCH);

  always_ff @(posedge clk) begin
    if (wr_en) mem[~front][wr_row] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      sh        <= '0;
      cnt       <= '0;
      ph        <= '0;
      lcnt      <= '0;
      sck       <= 1'b0;
      row       <= RW'(ROWS - 1);
      good      <= 2'd0;
      sync_lost <= 1'b1;
      front     <= 1'b0;
      swap_pend <= 1'b0;
      tap_seen  <= 1'b0;
      tap_q     <= 1'b0;
      strb_q    <= 1'b0;
    end else begin
      tap_q  <= tap_in;
      strb_q <= strb_in;
      if (acc) begin
        row       <= row_nx;
        good      <= good_nx;
        sync_lost <= lost_nx;
        front     <= front_nx;
        swap_pend <= 1'b0;
        tap_seen  <= 1'b0;
      end else begin
        swap_pend <= swap_pend || wr_swap;
        tap_seen  <= tap_hit;
      end
      case (st)
        IDLE: if (acc) begin
          sh  <= lost_nx ? '0 : TOT'(rd);
          cnt <= '0;
          ph  <= '0;
          sck <= 1'b0;
          st  <= SHIFT;
        end
        SHIFT: begin
          if (ph == PW'(DIV_HALF - 1)) begin
            ph <= '0;
            if (!sck) sck <= 1'b1;
            else begin
              sck <= 1'b0;
              sh  <= sh << 1;
              cnt <= cnt + 1'b1;
              if (cnt == CW'(TOT - 1)) begin
                st   <= LATCH;
                lcnt <= '0;
              end
            end
          end else ph <= ph + 1'b1;
        end
        LATCH: begin
          lcnt <= lcnt + 1'b1;
          if (lcnt == LW'(LATCH_LEN - 1)) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r2_sck_only_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SHIFT) |-> !sck);
  a_r2_sdo_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(sdo));
  a_r4_latch_after_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_out) |-> (cnt == CW'(TOT)));
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT && $past(st) == SHIFT) |-> (cnt >= $past(cnt)));
  a_r8_blank_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SHIFT && sync_lost) |-> !sdo);
  a_r7_lock_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_lost) |-> (good == 2'd2));
endmodule

// File: tb/sim_led_row_shifter.sv
`timescale 1ns/1ps
module sim_led_row_shifter;
  localparam int CB = 192, PAD = 8, DIV = 2, LL = 3, TOT = PAD + CB;

  logic clk = 0, rst_n = 0, strb = 0, tap = 0, wr_en = 0, wr_swap = 0;
  logic [3:0] wr_row = 0;
  logic [CB-1:0] wr_data = 0;
  logic sdo, sck, latch_out, sync_lost;

  led_row_shifter #(.CHAIN_BITS(CB), .ROWS(16), .PAD_BITS(PAD), .DIV_HALF(DIV), .LATCH_LEN(LL)) u0 (
    .clk(clk), .rst_n(rst_n), .strb_in(strb), .tap_in(tap), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .wr_swap(wr_swap), .sdo(sdo), .sck(sck), .latch_out(latch_out),
    .sync_lost(sync_lost));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, nbits = 0, per_bad = 0;
  logic [TOT-1:0] got;
  time t_last;
  logic [CB-1:0] bk [2][16];
  int m_row = 15, m_good = 0;
  bit m_lost = 1, m_front = 0, m_pend = 0;

  // segments: {tap on first slot, number of slots}
  localparam logic [6:0] SEG [6] = '{ {1'b1,6'd16}, {1'b1,6'd5}, {1'b1,6'd16},
                                      {1'b1,6'd16}, {1'b1,6'd16}, {1'b0,6'd1} };

  always @(posedge sck) begin
    if (nbits > 0 && ($time - t_last) != 2*DIV*5) per_bad++;
    t_last = $time;
    got = {got[TOT-2:0], sdo};
    nbits++;
  end

  function automatic logic [CB-1:0] pat(int r, bit inv);
    logic [CB-1:0] v;
    for (int k = 0; k < 6; k++) v[k*32 +: 32] = (32'h9E3779B9 * (r + 1)) ^ (32'h01234567 * (k + 3));
    return inv ? ~v : v;
  endfunction

  task automatic chk(bit ok, string req, logic [CB-1:0] act, logic [CB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int r, logic [CB-1:0] d);
    @(negedge clk); wr_en = 1; wr_row = 4'(r); wr_data = d;
    @(negedge clk); wr_en = 0;
    bk[~m_front][r] = d;
  endtask

  task automatic slot(bit t, bit extra);
    int lw;
    logic [CB-1:0] exp;
    bit mism;
    @(negedge clk); if (t) tap = 1;
    @(negedge clk); nbits = 0; got = '0; strb = 1;
    repeat (2) @(negedge clk); strb = 0; tap = 0;
    if (extra) begin repeat (40) @(negedge clk); strb = 1; repeat (2) @(negedge clk); strb = 0; end
    while (!latch_out) @(negedge clk);
    lw = 0;
    while (latch_out) begin lw++; @(negedge clk); end
    repeat (3) @(negedge clk);
    // model of R6/R7/R9
    mism = t != (m_row == 15);
    if (mism) begin m_good = 0; m_lost = 1; end
    else if (t) begin if (m_good < 2) m_good++; if (m_good == 2) m_lost = 0; end
    m_row = t ? 0 : (m_row + 1) % 16;
    m_front ^= m_pend; m_pend = 0;
    exp = m_lost ? '0 : bk[m_front][m_row];
    chk(nbits == TOT, "R2 bit count", CB'(nbits), CB'(TOT));
    chk(got[TOT-1:CB] == '0, "R3 pad bits", CB'(got[TOT-1:CB]), '0);
    chk(got[CB-1:0] == exp, m_lost ? "R8 blank word" : "R3 R6 R9 row word", got[CB-1:0], exp);
    chk(lw == LL, "R4 latch width", CB'(lw), CB'(LL));
    chk(sync_lost == m_lost, "R7 sync flag", CB'(sync_lost), CB'(m_lost));
  endtask

  initial begin
    #(5*200000);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!sck && !sdo && !latch_out && sync_lost, "R1 reset state",
        CB'({sck, sdo, latch_out, sync_lost}), CB'(4'b0001));
    rst_n = 1;
    @(negedge clk);
    chk(!sck && !sdo && !latch_out && sync_lost, "R1 after reset",
        CB'({sck, sdo, latch_out, sync_lost}), CB'(4'b0001));
    for (int r = 0; r < 16; r++) wr(r, pat(r, 0));
    @(negedge clk); wr_swap = 1; @(negedge clk); wr_swap = 0; m_pend = 1;

    for (int s = 0; s < 6; s++)
      for (int i = 0; i < int'(SEG[s][5:0]); i++) slot(i == 0 && SEG[s][6], 0);

    // R7 relock after the R6 wrap mismatch, then R9 hidden-bank writes
    for (int i = 0; i < 15; i++) slot(0, 0);
    slot(1, 0);
    for (int i = 0; i < 15; i++) slot(0, 0);
    slot(1, 0);
    chk(sync_lost == 0, "R7 relocked", CB'(sync_lost), '0);
    for (int r = 0; r < 16; r++) wr(r, pat(r, 1));
    slot(0, 0);
    @(negedge clk); wr_swap = 1; @(negedge clk); wr_swap = 0; m_pend = 1;
    slot(0, 0);
    // R5 extra strobe during a transfer
    slot(0, 1);
    slot(0, 0);
    chk(per_bad == 0, "R2 sck period", CB'(per_bad), '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule